// File: doc/BRIEF.md
# Single-Line Fault Injector

This block sits inline on a parallel bus of `N_LINES` signals and hands the bus on to its consumers. While no fault is armed, the bus passes straight through with no register in the path. A small control port picks one fault and one target line. The fault can be a line held at 0, a line held at 1, a short between a line and its upper neighbour that behaves as wired-AND or wired-OR, or a slow-to-settle line that shows its old value for a chosen number of cycles after each change. Only one fault is ever active, so the set of possible faults is the number of kinds times the number of lines.

The control fields are captured on every clock edge while `arm` is low and are frozen while `arm` is high. A fault is applied from the second cycle that `arm` is high. A short can only join line i to line i+1. Asking for a short on the top line, which has no upper neighbour, raises `cfg_err` and injects nothing. The faulted bus comes out on `bus_out`, and `fault_active` shows when a fault is being applied.

Top module: `fault_injector`

## Requirements
- R1: While `arm` is low, or while `rst_n` is low, `bus_out` equals `bus_in` in the same cycle and `fault_active` is 0. After reset the captured kind, line, polarity and hold are all 0.
- R2: Kind code 0 forces the target line to 0 and kind code 1 forces it to 1, whatever the input on that line. All other lines pass through unchanged.
- R3: Kind code 2 is a short between the target line L and line L+1. With `cfg_or`=0 both lines carry the AND of their two inputs. With `cfg_or`=1 both carry the OR. All other lines pass through.
- R4: If the captured kind is 2 and the captured line is N_LINES-1, or the captured line is N_LINES or above, `cfg_err` is 1, nothing is injected and `fault_active` stays 0.
- R5: Kind code 3 is a slow line. In a cycle where the target input differs from its value in the previous cycle and no hold is running, the output keeps the previous value. It keeps that value for D cycles in total, where D is the captured 3-bit hold, with 0 treated as 1. After that the line follows its input again.
- R6: While a slow-line hold is running, further input changes neither restart nor extend it. When the hold ends, the line shows the current input, so the error is never permanent.
- R7: The control fields are captured only on edges where `arm` is low. Changes made while `arm` is high have no effect on the output.
- R8: In the first cycle that `arm` is high, the bus still passes unchanged and `fault_active` is 0. The fault applies from the next cycle on.
- R9: When armed past the first cycle with a legal configuration, `fault_active` is 1. At most two lines of `bus_out` differ from `bus_in`, and only the target line, or its upper neighbour for a short, may differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Fault enable; control fields are captured while it is low |
| cfg_kind | input | 2 | Fault kind: 0 hold-low, 1 hold-high, 2 short, 3 slow line |
| cfg_line | input | $clog2(N_LINES) | Target line index |
| cfg_or | input | 1 | Short polarity: 0 wired-AND, 1 wired-OR |
| cfg_hold | input | HOLD_W | Slow-line hold length in cycles (0 means 1) |
| bus_in | input | N_LINES | Fault-free bus |
| bus_out | output | N_LINES | Bus with the fault applied |
| fault_active | output | 1 | A fault is being applied |
| cfg_err | output | 1 | Captured configuration is an illegal short |

## Verification
The bench sweeps every legal line for each static kind and both short polarities. This catches a short that drives only one side, or one that reaches into line L-1. It asks for a short on the top line, where a design without the check would index past the bus or fault line 0. It covers slow lines with every hold length, including 0: an off-by-one counter shows the stale value one cycle too long or too short. It also changes the input again in the middle of a hold, which exposes a design that re-arms the hold. It edits the controls while armed and checks the first armed cycle, catching designs that capture too late or inject one cycle early.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [1:0] {
    FK_LOW    = 2'd0,
    FK_HIGH   = 2'd1,
    FK_SHORT  = 2'd2,
    FK_SLOW   = 2'd3
  } fault_kind_e;
endpackage

// File: rtl/fi_cfg_reg.sv
module fi_cfg_reg
  import fi_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  fault_kind_e       kind_in,
  input  logic [IDX_W-1:0]  line_in,
  input  logic              or_in,
  input  logic [HOLD_W-1:0] hold_in,
  output fault_kind_e       kind_q,
  output logic [IDX_W-1:0]  line_q,
  output logic              or_q,
  output logic [HOLD_W-1:0] hold_q,
  output logic              armed_q
);

  logic cap_en;

  always_comb begin
    cap_en = ~arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= FK_LOW;
      line_q  <= '0;
      or_q    <= 1'b0;
      hold_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= arm;
      if (cap_en) begin
        kind_q <= kind_in;
        line_q <= line_in;
        or_q   <= or_in;
        hold_q <= hold_in;
      end
    end
  end

endmodule

// File: rtl/fi_slow_line.sv
module fi_slow_line #(
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              line_in,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              stale_on,
  output logic              stale_val
);

  logic              prev_q, prev_d;
  logic              held_q, held_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic [HOLD_W-1:0] len_eff;
  logic              edge_seen;
  logic              busy;

  always_comb begin
    len_eff   = (hold_len == '0) ? HOLD_W'(1) : hold_len;
    busy      = (cnt_q != '0);
    edge_seen = (line_in != prev_q);
    prev_d    = line_in;
    cnt_d     = cnt_q;
    held_d    = held_q;
    if (!en) begin
      cnt_d = '0;
    end else if (busy) begin
      cnt_d = cnt_q - HOLD_W'(1);
    end else if (edge_seen) begin
      cnt_d  = len_eff - HOLD_W'(1);
      held_d = prev_q;
    end
    stale_on  = en && (busy || edge_seen);
    stale_val = busy ? held_q : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      held_q <= held_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/fi_apply.sv
module fi_apply
  import fi_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [N_LINES-1:0] bus_in,
  input  logic               en,
  input  fault_kind_e        kind,
  input  logic [IDX_W-1:0]   line,
  input  logic               use_or,
  input  logic               stale_on,
  input  logic               stale_val,
  output logic [N_LINES-1:0] bus_out
);

  logic [N_LINES-1:0] pair_val;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic hit;
    logic upper;
    logic own_val;

    if (i < N_LINES - 1) begin : g_pair
      always_comb pair_val[i] = use_or ? (bus_in[i] | bus_in[i+1])
                                       : (bus_in[i] & bus_in[i+1]);
    end else begin : g_top
      always_comb pair_val[i] = bus_in[i];
    end

    if (i > 0) begin : g_up
      always_comb upper = en && (kind == FK_SHORT) && (line == IDX_W'(i - 1));
    end else begin : g_noup
      always_comb upper = 1'b0;
    end

    always_comb begin
      hit = en && (line == IDX_W'(i));
      unique case (kind)
        FK_LOW:   own_val = 1'b0;
        FK_HIGH:  own_val = 1'b1;
        FK_SHORT: own_val = pair_val[i];
        default:  own_val = stale_on ? stale_val : bus_in[i];
      endcase
    end

    if (i > 0) begin : g_out_up
      always_comb bus_out[i] = hit   ? own_val :
                               upper ? pair_val[i-1] : bus_in[i];
    end else begin : g_out0
      always_comb bus_out[i] = hit ? own_val : bus_in[i];
    end
  end

endmodule

// File: rtl/fault_injector.sv
module fault_injector
  import fi_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int HOLD_W  = 3,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [1:0]         cfg_kind,
  input  logic [IDX_W-1:0]   cfg_line,
  input  logic               cfg_or,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic [N_LINES-1:0] bus_in,
  output logic [N_LINES-1:0] bus_out,
  output logic               fault_active,
  output logic               cfg_err
);

  localparam int LAST = N_LINES - 1;

  fault_kind_e       kind_q;
  logic [IDX_W-1:0]  line_q;
  logic              or_q;
  logic [HOLD_W-1:0] hold_q;
  logic              armed_q;
  logic              bad_cfg;
  logic              inject;
  logic              slow_en;
  logic              stale_on;
  logic              stale_val;
  logic              tgt_bit;
  logic [IDX_W:0]    line_ext;

  fi_cfg_reg #(.IDX_W(IDX_W), .HOLD_W(HOLD_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .kind_in (fault_kind_e'(cfg_kind)),
    .line_in (cfg_line),
    .or_in   (cfg_or),
    .hold_in (cfg_hold),
    .kind_q  (kind_q),
    .line_q  (line_q),
    .or_q    (or_q),
    .hold_q  (hold_q),
    .armed_q (armed_q)
  );

  always_comb begin
    line_ext = {1'b0, line_q};
    bad_cfg  = (line_ext > (IDX_W+1)'(LAST)) ||
               ((kind_q == FK_SHORT) && (line_ext == (IDX_W+1)'(LAST)));
    inject   = arm && armed_q && !bad_cfg;
    slow_en  = inject && (kind_q == FK_SLOW);
    tgt_bit  = 1'b0;
    for (int k = 0; k < N_LINES; k++) begin
      if (line_q == IDX_W'(k)) tgt_bit = bus_in[k];
    end
  end

  fi_slow_line #(.HOLD_W(HOLD_W)) u_slow (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (slow_en),
    .line_in   (tgt_bit),
    .hold_len  (hold_q),
    .stale_on  (stale_on),
    .stale_val (stale_val)
  );

  fi_apply #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_apply (
    .bus_in    (bus_in),
    .en        (inject),
    .kind      (kind_q),
    .line      (line_q),
    .use_or    (or_q),
    .stale_on  (stale_on),
    .stale_val (stale_val),
    .bus_out   (bus_out)
  );

  always_comb begin
    fault_active = inject;
    cfg_err      = bad_cfg;
  end

endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
  parameter int N_LINES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm,
  input logic [N_LINES-1:0] bus_in,
  input logic [N_LINES-1:0] bus_out,
  input logic               fault_active,
  input logic               cfg_err
);

  logic arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm;
  end

  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> (bus_out == bus_in) && !fault_active);

  p_bad_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !fault_active && (bus_out == bus_in));

  p_first_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !arm_q) |-> !fault_active && (bus_out == bus_in));

  p_flag_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_active |-> arm && !cfg_err);

  p_few_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_out ^ bus_in) <= 2);

endmodule

bind fault_injector fi_checker #(.N_LINES(N_LINES)) u_fi_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm          (arm),
  .bus_in       (bus_in),
  .bus_out      (bus_out),
  .fault_active (fault_active),
  .cfg_err      (cfg_err)
);

// File: tb/tb_fault_injector.sv
module tb_fault_injector;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int HW = 3;

  logic          clk;
  logic          rst_n;
  logic          arm;
  logic [1:0]    kind_i;
  logic [IW-1:0] line_i;
  logic          or_i;
  logic [HW-1:0] hold_i;
  logic [N-1:0]  bus_in;
  logic [N-1:0]  bus_out;
  logic          active;
  logic          err;

  fault_injector #(.N_LINES(N), .HOLD_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_kind(kind_i), .cfg_line(line_i),
    .cfg_or(or_i), .cfg_hold(hold_i), .bus_in(bus_in), .bus_out(bus_out),
    .fault_active(active), .cfg_err(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [N-1:0] o;
    logic         a;
    logic         e;
    string        tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit rel_pending = 0;

  // reference state
  int   m_kind, m_line, m_hold, m_cnt;
  logic m_or, m_armed, m_prev, m_held;
  // requested configuration
  int   s_kind, s_line, s_hold;
  logic s_or;

  task automatic model_reset();
    m_kind = 0; m_line = 0; m_hold = 0; m_cnt = 0;
    m_or = 0; m_armed = 0; m_prev = 0; m_held = 0;
  endtask

  task automatic step(input logic a, input logic [N-1:0] v, input string tag);
    item_t it;
    logic bad_c, on, pv, n_held, n_prev;
    logic [N-1:0] e;
    int eff, n_cnt;
    @(negedge clk);
    if (rel_pending) begin rst_n = 1'b1; rel_pending = 0; end
    arm = a; bus_in = v;
    kind_i = s_kind[1:0]; line_i = s_line[IW-1:0]; or_i = s_or; hold_i = s_hold[HW-1:0];
    bad_c = (m_kind == 2 && m_line == N-1);
    on = a && m_armed && !bad_c && rst_n;
    e = v;
    if (on) begin
      case (m_kind)
        0: e[m_line] = 1'b0;
        1: e[m_line] = 1'b1;
        2: begin
          pv = m_or ? (v[m_line] | v[m_line+1]) : (v[m_line] & v[m_line+1]);
          e[m_line] = pv; e[m_line+1] = pv;
        end
        default: begin
          if (m_cnt != 0) e[m_line] = m_held;
          else if (v[m_line] != m_prev) e[m_line] = m_prev;
        end
      endcase
    end
    it.o = e; it.a = on; it.e = bad_c; it.tag = tag;
    q.push_back(it);
    eff = (m_hold == 0) ? 1 : m_hold;
    n_cnt = m_cnt; n_held = m_held; n_prev = v[m_line];
    if (!(on && m_kind == 3)) n_cnt = 0;
    else if (m_cnt != 0) n_cnt = m_cnt - 1;
    else if (v[m_line] != m_prev) begin n_cnt = eff - 1; n_held = m_prev; end
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      m_armed = a;
      if (!a) begin m_kind = s_kind; m_line = s_line; m_or = s_or; m_hold = s_hold; end
      m_prev = n_prev; m_cnt = n_cnt; m_held = n_held;
    end
  endtask

  function automatic logic [N-1:0] rnd();
    return N'($urandom);
  endfunction

  task automatic session(input int k, input int l, input logic o, input int h,
                         input int cyc, input string tag);
    s_kind = k; s_line = l; s_or = o; s_hold = h;
    step(1'b0, rnd(), "R1");
    step(1'b0, rnd(), "R1");
    step(1'b1, rnd(), "R8");
    step(1'b1, rnd(), "R9");
    for (int c = 0; c < cyc; c++) step(1'b1, rnd(), tag);
    step(1'b0, rnd(), "R1");
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (bus_out !== it.o || active !== it.a || err !== it.e) begin
          bad++;
          $display("FAIL %s out=%h act=%b err=%b expected out=%h act=%b err=%b",
                   it.tag, bus_out, active, err, it.o, it.a, it.e);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    rst_n = 1'b0; arm = 1'b0; bus_in = '0;
    kind_i = '0; line_i = '0; or_i = 1'b0; hold_i = '0;
    s_kind = 2; s_line = N-1; s_or = 1'b1; s_hold = 5;
    model_reset();
    // R1: reset passthrough, inputs ignored while held in reset
    step(1'b0, rnd(), "R1");
    step(1'b0, rnd(), "R1");
    rel_pending = 1;
    s_kind = 0; s_line = 0; s_or = 0; s_hold = 0;
    step(1'b0, rnd(), "R1");
    // R2: stuck lines on every index
    for (int l = 0; l < N; l++) begin
      session(0, l, 1'b0, 0, 4, "R2");
      session(1, l, 1'b0, 0, 4, "R2");
    end
    // R3: shorts, both polarities
    for (int l = 0; l < N-1; l++) begin
      session(2, l, 1'b0, 0, 6, "R3");
      session(2, l, 1'b1, 0, 6, "R3");
    end
    // R4: short on top line rejected
    session(2, N-1, 1'b0, 0, 5, "R4");
    session(2, N-1, 1'b1, 0, 5, "R4");
    // R5: slow line, holds 0..7 across all lines
    for (int l = 0; l < N; l++) session(3, l, 1'b0, l % 8, 20, "R5");
    // R6: a second change during a hold of 3 on line 5
    s_kind = 3; s_line = 5; s_or = 0; s_hold = 3;
    step(1'b0, '0, "R1");
    step(1'b0, '0, "R1");
    step(1'b1, '0, "R8");
    step(1'b1, '0, "R6");
    for (int c = 0; c < 8; c++) begin
      v = rnd();
      v[5] = (c == 0) || (c == 3);
      step(1'b1, v, "R6");
    end
    step(1'b0, rnd(), "R1");
    // R7: control edits while armed are ignored
    s_kind = 1; s_line = 3; s_or = 0; s_hold = 0;
    step(1'b0, '0, "R1");
    step(1'b0, '0, "R1");
    step(1'b1, '0, "R8");
    s_kind = 0; s_line = 7; s_or = 1;
    for (int c = 0; c < 6; c++) step(1'b1, rnd() & ~N'(1 << 3), "R7");
    step(1'b0, rnd(), "R1");
    s_kind = 2; s_line = N-1;
    for (int c = 0; c < 4; c++) step(1'b1, rnd(), "R7");
    step(1'b0, rnd(), "R1");
    step(1'b0, rnd(), "R4");
    @(negedge clk);
    #3;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule